// File: doc/BRIEF.md
# Two-Channel Hardware Breakpoint Comparator

This block watches the cycles of two bus sources and raises a break request to the processor when a cycle meets the conditions programmed into either of its two channels. Each channel compares a masked address, an 8-bit address-space identifier and three two-bit qualifier groups. The groups select the bus source, fetch versus data access, and read versus write. The second channel, B, can also compare masked data.

Software programs the channels through a small register port. A hit sets a sticky flag for the channel and bus source that matched, and only a software write of 0 clears it. The break request is a registered one-cycle pulse. It stays quiet after that until the processor acknowledges it, so hits on both channels in the same window produce one request.

Register map (word index on `cfg_addr`): 0 A address, 1 A address mask, 2 A identifier, 3 A cycle qualifiers, 4 B address, 5 B address mask, 6 B identifier, 7 B cycle qualifiers, 8 B data, 9 B data mask, 10 match flags. Any other index reads 0.

Top module: `brk_unit`

## Requirements
- R1: After reset every register reads 0, `brk_req` is low and no cycle matches, because all qualifier groups are 00.
- R2: A channel's address register must equal the cycle address at every bit where the address mask register holds 0. Mask bits set to 1 are ignored.
- R3: The cycle identifier must equal all 8 bits of the channel's identifier register.
- R4: Channel B also requires the cycle data to equal its data register at every bit where its data mask holds 0. Channel A ignores data.
- R5: Qualifier register bits [1:0] select the bus source (01 bus 0, 10 bus 1, 11 either). Bits [3:2] select the access kind (01 fetch, 10 data access, 11 either). Bits [5:4] select the direction (01 read, 10 write, 11 either).
- R6: If any qualifier group of a channel is 00, that channel never matches.
- R7: A match sets the flag for the matching channel and bus source. Flag register bits are: bit 0 A/bus 0, bit 1 A/bus 1, bit 2 B/bus 0, bit 3 B/bus 1.
- R8: Flags are sticky. Hardware never clears them. A write to the flag register clears each bit written 0 and leaves each bit written 1 unchanged.
- R9: When a hardware set and a software clear hit the same flag in the same cycle, the flag ends up set.
- R10: A match drives `brk_req` high for exactly one cycle, on the clock edge that ends the matching cycle.
- R11: After a request, further matches raise no request until `brk_ack` is seen. Coincident matches on both channels give one request while setting every matching flag.
- R12: Every configuration register reads back the value last written, through `cfg_rdata`, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register index |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for `cfg_addr` |
| b0_valid | input | 1 | Bus 0 cycle present |
| b0_addr | input | 32 | Bus 0 address |
| b0_asid | input | 8 | Bus 0 address-space identifier |
| b0_fetch | input | 1 | Bus 0 cycle is an instruction fetch (0 = data access) |
| b0_write | input | 1 | Bus 0 cycle is a write (0 = read) |
| b0_data | input | 32 | Bus 0 data |
| b1_valid | input | 1 | Bus 1 cycle present |
| b1_addr | input | 32 | Bus 1 address |
| b1_asid | input | 8 | Bus 1 address-space identifier |
| b1_fetch | input | 1 | Bus 1 cycle is an instruction fetch |
| b1_write | input | 1 | Bus 1 cycle is a write |
| b1_data | input | 32 | Bus 1 data |
| brk_ack | input | 1 | Processor acknowledges the break request |
| brk_req | output | 1 | Break request pulse |

## Verification
Some properties are checked on every cycle by assertions:
- the request is one cycle wide and always follows a match while no request is outstanding;
- every match sets its flag;
- a flag falls only after a write to the flag register;
- a channel with a 00 group never matches.

Other behaviour can only be shown by the bench's scenarios against values worked out from the requirements: the masked address, identifier and data comparisons, each qualifier encoding, the readback of registers, the merging of coincident requests, and the set-over-clear priority.

// File: rtl/brk_unit.sv
module brk_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_we,
  input  logic [3:0]   cfg_addr,
  input  logic [W-1:0] cfg_wdata,
  output logic [W-1:0] cfg_rdata,
  input  logic         b0_valid,
  input  logic [W-1:0] b0_addr,
  input  logic [7:0]   b0_asid,
  input  logic         b0_fetch,
  input  logic         b0_write,
  input  logic [W-1:0] b0_data,
  input  logic         b1_valid,
  input  logic [W-1:0] b1_addr,
  input  logic [7:0]   b1_asid,
  input  logic         b1_fetch,
  input  logic         b1_write,
  input  logic [W-1:0] b1_data,
  input  logic         brk_ack,
  output logic         brk_req
);
  localparam logic [3:0] IX_FLAGS = 4'd10;

  logic [W-1:0] a_addr, a_amask, b_addr, b_amask, b_data, b_dmask;
  logic [7:0]   a_asid, b_asid;
  logic [5:0]   a_cyc, b_cyc;
  logic [3:0]   flags;
  logic         pending;
  logic [3:0]   hit;

  function automatic logic pick(input logic [1:0] g, input logic second);
    return second ? g[1] : g[0];
  endfunction

  function automatic logic qual_ok(input logic [5:0] c, input logic bus1,
                                   input logic fetch, input logic wr);
    return pick(c[1:0], bus1) & pick(c[3:2], ~fetch) & pick(c[5:4], wr);
  endfunction

  assign hit[0] = b0_valid & qual_ok(a_cyc, 1'b0, b0_fetch, b0_write) &
                  (((b0_addr ^ a_addr) & ~a_amask) == '0) & (b0_asid == a_asid);
  assign hit[1] = b1_valid & qual_ok(a_cyc, 1'b1, b1_fetch, b1_write) &
                  (((b1_addr ^ a_addr) & ~a_amask) == '0) & (b1_asid == a_asid);
  assign hit[2] = b0_valid & qual_ok(b_cyc, 1'b0, b0_fetch, b0_write) &
                  (((b0_addr ^ b_addr) & ~b_amask) == '0) & (b0_asid == b_asid) &
                  (((b0_data ^ b_data) & ~b_dmask) == '0);
  assign hit[3] = b1_valid & qual_ok(b_cyc, 1'b1, b1_fetch, b1_write) &
                  (((b1_addr ^ b_addr) & ~b_amask) == '0) & (b1_asid == b_asid) &
                  (((b1_data ^ b_data) & ~b_dmask) == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_addr <= '0; a_amask <= '0; a_asid <= '0; a_cyc <= '0;
      b_addr <= '0; b_amask <= '0; b_asid <= '0; b_cyc <= '0;
      b_data <= '0; b_dmask <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        4'd0: a_addr  <= cfg_wdata;
        4'd1: a_amask <= cfg_wdata;
        4'd2: a_asid  <= cfg_wdata[7:0];
        4'd3: a_cyc   <= cfg_wdata[5:0];
        4'd4: b_addr  <= cfg_wdata;
        4'd5: b_amask <= cfg_wdata;
        4'd6: b_asid  <= cfg_wdata[7:0];
        4'd7: b_cyc   <= cfg_wdata[5:0];
        4'd8: b_data  <= cfg_wdata;
        4'd9: b_dmask <= cfg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags   <= '0;
      pending <= 1'b0;
      brk_req <= 1'b0;
    end else begin
      flags   <= ((cfg_we && cfg_addr == IX_FLAGS) ? (flags & cfg_wdata[3:0]) : flags) | hit;
      brk_req <= !pending && (|hit);
      pending <= pending ? !brk_ack : (|hit);
    end
  end

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      4'd0: cfg_rdata = a_addr;
      4'd1: cfg_rdata = a_amask;
      4'd2: cfg_rdata[7:0] = a_asid;
      4'd3: cfg_rdata[5:0] = a_cyc;
      4'd4: cfg_rdata = b_addr;
      4'd5: cfg_rdata = b_amask;
      4'd6: cfg_rdata[7:0] = b_asid;
      4'd7: cfg_rdata[5:0] = b_cyc;
      4'd8: cfg_rdata = b_data;
      4'd9: cfg_rdata = b_dmask;
      IX_FLAGS: cfg_rdata[3:0] = flags;
      default: ;
    endcase
  end
endmodule

// File: rtl/brk_unit_chk.sv
module brk_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_we,
  input logic [3:0] cfg_addr,
  input logic [5:0] a_cyc,
  input logic [5:0] b_cyc,
  input logic [3:0] hit,
  input logic [3:0] flags,
  input logic       pending,
  input logic       brk_req
);
  p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |=> !brk_req);

  p_req_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> $past(|hit));

  p_one_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> !$past(pending));

  p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit) |=> ((flags & $past(hit)) == $past(hit)));

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(flags) & ~flags)) |-> $past(cfg_we && cfg_addr == 4'd10));

  p_disable_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (a_cyc[1:0] == 2'b00 || a_cyc[3:2] == 2'b00 || a_cyc[5:4] == 2'b00) |-> (hit[1:0] == 2'b00));

  p_disable_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (b_cyc[1:0] == 2'b00 || b_cyc[3:2] == 2'b00 || b_cyc[5:4] == 2'b00) |-> (hit[3:2] == 2'b00));
endmodule

bind brk_unit brk_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .a_cyc(a_cyc), .b_cyc(b_cyc), .hit(hit), .flags(flags),
  .pending(pending), .brk_req(brk_req)
);

// File: tb/sim_brk_unit.sv
`timescale 1ns/1ps
module sim_brk_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        b0_valid = 1'b0, b0_fetch = 1'b0, b0_write = 1'b0;
  logic [31:0] b0_addr = '0, b0_data = '0;
  logic [7:0]  b0_asid = '0;
  logic        b1_valid = 1'b0, b1_fetch = 1'b0, b1_write = 1'b0;
  logic [31:0] b1_addr = '0, b1_data = '0;
  logic [7:0]  b1_asid = '0;
  logic        brk_ack = 1'b0;
  logic        brk_req;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  brk_unit u0 (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    cfg_addr = a;
    #0.5;
    d = cfg_rdata;
  endtask

  // one bus cycle, returns with the edge that ends it already taken
  task automatic bus(input bit which, input logic [31:0] a, input logic [7:0] id,
                     input logic f, input logic w, input logic [31:0] d);
    @(negedge clk);
    if (!which) begin
      b0_valid = 1'b1; b0_addr = a; b0_asid = id; b0_fetch = f; b0_write = w; b0_data = d;
    end else begin
      b1_valid = 1'b1; b1_addr = a; b1_asid = id; b1_fetch = f; b1_write = w; b1_data = d;
    end
    @(negedge clk);
    b0_valid = 1'b0; b1_valid = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk); brk_ack = 1'b1;
    @(negedge clk); brk_ack = 1'b0;
  endtask

  task automatic clear_all();
    ack();
    wr(4'd10, 32'h0);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int i = 0; i < 11; i++) begin
      rd(i[3:0], v);
      check("R1 reg reset", v, 32'h0);
    end
    check("R1 req reset", {31'b0, brk_req}, 32'h0);
    bus(1'b0, 32'h0, 8'h0, 1'b1, 1'b0, 32'h0);
    check("R1 no match after reset", {31'b0, brk_req}, 32'h0);
    rd(4'd10, v);
    check("R1 flags after reset cycle", v, 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(4'd0, 32'h1234_5678);
    wr(4'd9, 32'hA5A5_0F0F);
    wr(4'd6, 32'hFFFF_FF3C);
    rd(4'd0, v); check("R12 A address", v, 32'h1234_5678);
    rd(4'd9, v); check("R12 B data mask", v, 32'hA5A5_0F0F);
    rd(4'd6, v); check("R12 B identifier", v, 32'h0000_003C);
  endtask

  task automatic t_addr();
    logic [31:0] v;
    wr(4'd0, 32'h0000_1000); wr(4'd1, 32'h0000_000F);
    wr(4'd2, 32'h05);        wr(4'd3, 32'h3F);
    bus(1'b0, 32'h0000_100C, 8'h05, 1'b0, 1'b1, 32'h0);
    check("R10 request after masked match", {31'b0, brk_req}, 32'h1);
    rd(4'd10, v); check("R7 flag A bus0", v, 32'h1);
    @(negedge clk);
    check("R10 request one cycle", {31'b0, brk_req}, 32'h0);
    clear_all();
    bus(1'b0, 32'h0000_1010, 8'h05, 1'b0, 1'b1, 32'h0);
    check("R2 unmasked address bit differs", {31'b0, brk_req}, 32'h0);
  endtask

  task automatic t_asid();
    logic [31:0] v;
    bus(1'b0, 32'h0000_1003, 8'h06, 1'b1, 1'b0, 32'h0);
    check("R3 identifier mismatch", {31'b0, brk_req}, 32'h0);
    rd(4'd10, v); check("R3 no flag", v, 32'h0);
  endtask

  task automatic t_qual();
    logic [31:0] v;
    wr(4'd3, 32'h26);
    bus(1'b0, 32'h0000_1000, 8'h05, 1'b1, 1'b1, 32'h0);
    check("R5 wrong bus source", {31'b0, brk_req}, 32'h0);
    bus(1'b1, 32'h0000_1000, 8'h05, 1'b0, 1'b1, 32'h0);
    check("R5 data access vs fetch", {31'b0, brk_req}, 32'h0);
    bus(1'b1, 32'h0000_1000, 8'h05, 1'b1, 1'b0, 32'h0);
    check("R5 read vs write", {31'b0, brk_req}, 32'h0);
    bus(1'b1, 32'h0000_1000, 8'h05, 1'b1, 1'b1, 32'h0);
    check("R5 all qualifiers met", {31'b0, brk_req}, 32'h1);
    rd(4'd10, v); check("R7 flag A bus1", v, 32'h2);
    clear_all();
  endtask

  task automatic t_disable();
    wr(4'd3, 32'h3C);
    bus(1'b0, 32'h0000_1000, 8'h05, 1'b1, 1'b0, 32'h0);
    check("R6 bus group 00", {31'b0, brk_req}, 32'h0);
    wr(4'd3, 32'h0F);
    bus(1'b1, 32'h0000_1000, 8'h05, 1'b0, 1'b1, 32'h0);
    check("R6 direction group 00", {31'b0, brk_req}, 32'h0);
  endtask

  task automatic t_data();
    logic [31:0] v;
    wr(4'd4, 32'h0000_2000); wr(4'd5, 32'h0);
    wr(4'd6, 32'h09);        wr(4'd8, 32'hCAFE_0000);
    wr(4'd9, 32'h0000_FFFF); wr(4'd7, 32'h3F);
    bus(1'b0, 32'h0000_2000, 8'h09, 1'b0, 1'b1, 32'hCAFF_0000);
    check("R4 unmasked data bit differs", {31'b0, brk_req}, 32'h0);
    bus(1'b0, 32'h0000_2000, 8'h09, 1'b0, 1'b1, 32'hCAFE_1234);
    check("R4 masked data match", {31'b0, brk_req}, 32'h1);
    rd(4'd10, v); check("R7 flag B bus0", v, 32'h4);
    ack();
  endtask

  task automatic t_sticky();
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rd(4'd10, v); check("R8 flag held by hardware", v, 32'h4);
    wr(4'd10, 32'hF);
    rd(4'd10, v); check("R8 write 1 keeps flag", v, 32'h4);
    wr(4'd10, 32'h0);
    rd(4'd10, v); check("R8 write 0 clears flag", v, 32'h0);
  endtask

  task automatic t_merge();
    logic [31:0] v;
    wr(4'd0, 32'h0000_2000); wr(4'd1, 32'h0);
    wr(4'd2, 32'h09);        wr(4'd3, 32'h3F);
    bus(1'b0, 32'h0000_2000, 8'h09, 1'b0, 1'b0, 32'hCAFE_0000);
    check("R11 coincident hits one request", {31'b0, brk_req}, 32'h1);
    rd(4'd10, v); check("R11 both channel flags", v, 32'h5);
    @(negedge clk);
    check("R11 no second pulse", {31'b0, brk_req}, 32'h0);
    bus(1'b1, 32'h0000_2000, 8'h09, 1'b1, 1'b0, 32'hCAFE_0000);
    check("R11 suppressed until ack", {31'b0, brk_req}, 32'h0);
    rd(4'd10, v); check("R11 flags still set while suppressed", v, 32'hF);
    ack();
    bus(1'b1, 32'h0000_2000, 8'h09, 1'b1, 1'b0, 32'hCAFE_0000);
    check("R11 request after ack", {31'b0, brk_req}, 32'h1);
    ack();
  endtask

  task automatic t_prio();
    logic [31:0] v;
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'd10; cfg_wdata = 32'h0;
    b0_valid = 1'b1; b0_addr = 32'h0000_2000; b0_asid = 8'h09;
    b0_fetch = 1'b0; b0_write = 1'b0; b0_data = 32'h0;
    @(negedge clk);
    cfg_we = 1'b0; b0_valid = 1'b0;
    rd(4'd10, v); check("R9 set wins over clear", v, 32'h1);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_addr();
    t_asid();
    t_qual();
    t_disable();
    t_data();
    t_sticky();
    t_merge();
    t_prio();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule